// File: doc/BRIEF.md
# Microsecond Time-Stamp Counter with Fractional Prescaler

This block keeps a free-running up-counter that advances once per microsecond. The count rate comes from a peripheral oscillator whose rising edges reach the block as a one-cycle enable, `osc_en`, in the system clock domain. A fractional prescaler turns those enables into microsecond ticks, using a ratio of two small integer fields held in a configuration register. The count wraps silently, raises no interrupt and needs no setup after reset. A freeze register halts both the counter and the prescaler, for example while a debugger has the system stopped.

Software reaches the block over a simple register bus. A write is taken on any clock edge where `bus_sel` and `bus_wr` are high. A read returns data combinationally from `bus_addr` in the same cycle. The bus has no back-pressure: every access completes in one cycle, so there is no valid/ready pair. The only stream-like input is `osc_en`, and it is a plain qualifier.

Top module: `usc_timer_top`

## Requirements
- R1: The count register is 32 bits wide. It increases by exactly one for each prescaler tick, goes from 0xFFFFFFFF to 0 with no other output, and never changes by any other amount.
- R2: The configuration register holds the numerator field N in bits 15:8 and the denominator field M in bits 7:0. Each field stores its value minus one. Bits 31:16 are not stored and read as 0.
- R3: The prescaler accumulator starts cleared. When N <= M, after K enabled oscillator cycles the counter has advanced by floor(K*(N+1)/(M+1)). Cycles with `osc_en` low have no effect.
- R4: When N > M (a ratio above one), the counter advances by one on every enabled oscillator cycle.
- R5: The register offsets are fixed. The count is at 0x00, the configuration at 0x04 and the freeze register at 0x3C. Any other offset reads 0.
- R6: While bit 0 of the freeze register (offset 0x3C) is 1, the counter holds its value and the accumulator keeps its contents. The other bits of the freeze register read 0.
- R7: The count register is read-only. A write to offset 0x00 leaves the count unchanged.
- R8: Every write to the configuration register clears the accumulator, and no tick is made in that cycle.
- R9: After reset the count is 0, the configuration reads 0x0000000B and freeze reads 0. With the reset configuration, the counter advances once every 12 enabled cycles without any register being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | One-cycle qualifier per oscillator clock |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | High for write, low for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |

## Verification
The prescaler is driven with a set of numerator/denominator pairs. These include the reset ratio, a run that stops one cycle short of the first tick, ratios that do not reduce to an integer divider (3/10, 5/7, 3/5), the largest divider, a unity ratio and a ratio above one. A fractional accumulator and a plain integer divider give different tick counts on these pairs, and the pairs also expose off-by-one errors in the threshold. Directed runs split a tick interval across a freeze and across a rewrite of the configuration, which shows whether the accumulator is held or cleared. A second instance with a narrow counter is taken through all-ones to zero to check the wrap.

// File: rtl/usc_pkg.sv
package usc_pkg;
  localparam int FIELD_W = 8;
  localparam logic [7:0] OFS_COUNT  = 8'h00;
  localparam logic [7:0] OFS_CFG    = 8'h04;
  localparam logic [7:0] OFS_FREEZE = 8'h3C;
  localparam logic [2*FIELD_W-1:0] CFG_RESET = 16'h000B;

  typedef struct packed {
    logic [FIELD_W-1:0] numer;  // ratio numerator minus one
    logic [FIELD_W-1:0] denom;  // ratio denominator minus one
  } ratio_cfg_t;
endpackage

// File: rtl/usc_prescaler.sv
module usc_prescaler #(
  parameter int FW = usc_pkg::FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic [FW-1:0] numer,
  input  logic [FW-1:0] denom,
  output logic          tick
);
  localparam int AW = FW + 2;

  logic [AW-1:0] acc_q, acc_d, step, limit, sum, rem;
  logic          hit;

  always_comb begin
    step  = AW'(numer) + AW'(1);
    limit = AW'(denom) + AW'(1);
    sum   = acc_q + step;
    hit   = (sum >= limit);
    rem   = sum - limit;
    if (!hit)              acc_d = sum;
    else if (rem >= limit) acc_d = '0;   // ratio above one: one tick per cycle
    else                   acc_d = rem;
    tick  = run && hit && !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else if (run) acc_q <= acc_d;
  end

  AST_ACC_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < limit);  // R3
  AST_CFG_CLEARS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));  // R8
  AST_ACC_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(acc_q));  // R6
endmodule

// File: rtl/usc_counter.sv
module usc_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + CW'(1);
  end

  AST_CNT_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count) || count == $past(count) + CW'(1)));  // R1
endmodule

// File: rtl/usc_regs.sv
module usc_regs #(
  parameter int AW_BUS = 8,
  parameter int DW     = 32,
  parameter int CW     = 32,
  parameter int FW     = usc_pkg::FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [AW_BUS-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [CW-1:0]     count,
  output logic [DW-1:0]     rdata,
  output usc_pkg::ratio_cfg_t cfg,
  output logic              cfg_wr,
  output logic              frozen
);
  import usc_pkg::*;
  localparam int CFG_W = 2 * FW;

  logic wr_freeze;

  always_comb begin
    cfg_wr    = sel && wr && (addr == AW_BUS'(OFS_CFG));
    wr_freeze = sel && wr && (addr == AW_BUS'(OFS_FREEZE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= CFG_RESET;
      frozen <= 1'b0;
    end else begin
      if (cfg_wr)    cfg    <= wdata[CFG_W-1:0];
      if (wr_freeze) frozen <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW_BUS'(OFS_COUNT))       rdata = DW'(count);
    else if (addr == AW_BUS'(OFS_CFG))    rdata = DW'(cfg);
    else if (addr == AW_BUS'(OFS_FREEZE)) rdata = DW'(frozen);
  end

  AST_CFG_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg));  // R2
endmodule

// File: rtl/usc_timer_top.sv
module usc_timer_top #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  import usc_pkg::*;

  ratio_cfg_t       cfg;
  logic             cfg_wr, frozen, tick;
  logic [CNT_W-1:0] count;
  logic             run;

  assign run = osc_en && !frozen;

  usc_regs #(.AW_BUS(ADDR_W), .DW(DATA_W), .CW(CNT_W), .FW(FIELD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .count(count), .rdata(bus_rdata), .cfg(cfg),
    .cfg_wr(cfg_wr), .frozen(frozen)
  );

  usc_prescaler #(.FW(FIELD_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(cfg_wr),
    .numer(cfg.numer), .denom(cfg.denom), .tick(tick)
  );

  usc_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(tick), .count(count)
  );

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(count));  // R6
  AST_IDLE_OSC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> $stable(count));  // R3
  AST_COUNT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_COUNT) && !osc_en)
      |=> $stable(count));  // R7
endmodule

// File: tb/sim_usc_timer_top.sv
module sim_usc_timer_top;
  logic        clk = 0, rst_n = 0, osc_en = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, rdata0, rdata1;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  usc_timer_top u0 (.clk(clk), .rst_n(rst_n), .osc_en(osc_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0));
  usc_timer_top #(.CNT_W(8)) u1 (.clk(clk), .rst_n(rst_n), .osc_en(osc_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata1));

  // {numer-1, denom-1, enabled cycles, expected advance}
  localparam logic [47:0] VEC [0:7] = '{
    {8'd0,   8'd11,  16'd120, 16'd10},
    {8'd0,   8'd11,  16'd11,  16'd0},
    {8'd2,   8'd9,   16'd100, 16'd30},
    {8'd4,   8'd6,   16'd35,  16'd25},
    {8'd2,   8'd4,   16'd9,   16'd5},
    {8'd0,   8'd255, 16'd600, 16'd2},
    {8'd255, 8'd255, 16'd7,   16'd7},
    {8'd1,   8'd0,   16'd20,  16'd20}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d0, output logic [31:0] d1);
    @(negedge clk); bus_sel = 0; bus_addr = a; #1 d0 = rdata0; d1 = rdata1;
  endtask

  task automatic run(int n);
    if (n > 0) begin
      @(negedge clk); osc_en = 1;
      repeat (n) @(posedge clk);
      #1 osc_en = 0;
    end
  endtask

  initial begin
    logic [31:0] a, b, c0, c1, u1c;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(8'h00, a, b); chk("R9 reset count", a, 0);
    rd(8'h04, a, b); chk("R9 reset cfg", a, 32'h0000000B);
    rd(8'h3C, a, b); chk("R9 reset freeze", a, 0);
    run(24);
    rd(8'h00, a, b); chk("R9 runs without setup", a, 2);

    for (int i = 0; i < 8; i++) begin
      wr(8'h04, {16'h0, VEC[i][47:32]});
      rd(8'h04, a, b); chk("R2 cfg readback", a, {16'h0, VEC[i][47:32]});
      rd(8'h00, c0, b);
      run(int'(VEC[i][31:16]));
      rd(8'h00, c1, b);
      chk(VEC[i][47:40] > VEC[i][39:32] ? "R4 ratio above one" : "R3 fractional rate",
          c1 - c0, {16'h0, VEC[i][15:0]});
    end

    wr(8'h04, 32'hFFFF_1234);
    rd(8'h04, a, b); chk("R2 upper cfg bits dropped", a, 32'h0000_1234);
    rd(8'h10, a, b); chk("R5 unmapped offset", a, 0);

    // R8: accumulator cleared by config rewrite
    wr(8'h04, 32'h0000_000B);
    rd(8'h00, c0, b);
    run(11); wr(8'h04, 32'h0000_000B); run(11);
    rd(8'h00, c1, b); chk("R8 rewrite clears accumulator", c1 - c0, 0);
    run(1);
    rd(8'h00, c1, b); chk("R8 tick after full interval", c1 - c0, 1);

    // R6: freeze holds counter and accumulator
    wr(8'h04, 32'h0000_000B);
    rd(8'h00, c0, b);
    run(6); wr(8'h3C, 32'h1);
    rd(8'h3C, a, b); chk("R6 freeze reads set", a, 1);
    run(30);
    rd(8'h00, c1, b); chk("R6 frozen count held", c1 - c0, 0);
    wr(8'h3C, 32'hFFFF_FFFE);
    rd(8'h3C, a, b); chk("R6 freeze upper bits read 0", a, 0);
    run(5);
    rd(8'h00, c1, b); chk("R6 accumulator kept partial", c1 - c0, 0);
    run(1);
    rd(8'h00, c1, b); chk("R6 tick after resume", c1 - c0, 1);

    // R7: count is read-only
    rd(8'h00, c0, b);
    wr(8'h00, 32'h1234_5678);
    rd(8'h00, c1, b); chk("R7 count write ignored", c1, c0);

    // R1: wrap on the narrow instance, unit steps on the wide one
    wr(8'h04, 32'h0);
    rd(8'h00, c0, u1c);
    run(255);
    rd(8'h00, c1, b); chk("R1 narrow at 255 steps", b, (u1c + 255) & 32'hFF);
    chk("R1 wide advanced", c1 - c0, 255);
    run(1);
    rd(8'h00, c1, b); chk("R1 narrow wrapped", b, u1c);
    chk("R1 wide no wrap", c1 - c0, 256);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule